// File: doc/BRIEF.md
# Serial Hit-List Formatter with Token Readout

This block sits between a daisy chain of strip front-end chips and an acquisition module. When a read request arrives it takes in the serial records that the chain produces, one record per chip in chain order. Each record has a presence bit, an optional 64-bit channel image and a 2-bit trigger code. The block counts the incoming bits, turns every set channel bit into an absolute strip address, and checks that all chips report the same trigger code.

Finished events go into one of two event stores. A new event can therefore be collected while an older one waits for readout. When the readout token reaches the block, it sends its oldest stored event as a header word followed by the strip addresses, with an even-parity bit on every word. It then passes the token on. If the token arrives while an event is still being collected, the block first waits for that event to finish. If the token arrives when there is nothing to send, the block passes it on at once.

Top module: `hitlist_fmt`

## Requirements
- R1: A read request (`read_evt` high while the block is idle and an event store is free) starts collection. From the next cycle, each cycle with `ser_vld` high consumes one bit of `ser_bit`. Per chip the bits are: presence bit, then 64 channel bits (channel 0 first) only if the presence bit is 1, then the trigger code most significant bit first. A 1 on channel k of the chip at chain position c (0 is the first record) yields address c*64+k.
- R2: A chip whose presence bit is 0 yields no addresses, but the next chip's addresses still start at (c+1)*64.
- R3: If any chip's trigger code differs from the first chip's, the event's mismatch flag is set. `mism_err` is then high for exactly the one cycle after the final bit of that event.
- R4: At most 64 addresses are kept per event, in arrival order. Any further hits are dropped, and the overflow flag is set.
- R5: The header word is {hit count[6:0], first chip's trigger code[1:0], mismatch, overflow} in bits 10..0. The addresses follow in arrival order, each 11 bits wide, on consecutive cycles with `out_vld` high. `out_last` marks the final word of the frame.
- R6: `out_par` makes the number of ones in {`out_data`,`out_par`} even.
- R7: A `token_in` pulse that arrives when the oldest event is stored puts the header out in the next cycle. `token_out` is high for exactly one cycle, in the cycle after the last word, and that event store is then freed.
- R8: A token that arrives during collection is held. The frame starts two cycles after the final serial bit.
- R9: A token that arrives while no event is stored or being collected gives `token_out` in the next cycle and no words.
- R10: Two stored events are sent oldest first. A read request made while both stores are full is ignored, together with any serial bits that follow it.
- R11: During and right after reset, `out_vld`, `token_out` and `mism_err` are low.
- R12: Cycles with `ser_vld` low during collection consume nothing.
- R13: The chip count is taken from `cfg_chips` when the read request is accepted. Later changes do not affect the event in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chips | input | 5 | Number of chips in the chain (1..24) |
| read_evt | input | 1 | Read request pulse |
| ser_vld | input | 1 | Serial bit qualifier |
| ser_bit | input | 1 | Serial record bit |
| token_in | input | 1 | Readout token pulse from upstream |
| out_vld | output | 1 | Output word valid |
| out_data | output | 11 | Header or strip address |
| out_par | output | 1 | Even-parity bit of out_data |
| out_last | output | 1 | Last word of the frame |
| mism_err | output | 1 | Trigger-code mismatch pulse |
| token_out | output | 1 | Token passed downstream |

## Verification
Every serial bit takes effect at the rising edge that samples it. Because of this, `mism_err` is due in the single cycle that follows the final trigger bit. A token accepted at an edge yields the header, or the downstream token in the empty case, in the very next cycle. `token_out` comes one cycle after the last address. A held token starts its frame one cycle after the event store fills, which is two cycles after the final bit. The bench's behavioural model advances on each rising edge from the same inputs and holds the outputs it expects for the coming cycle. The design is compared with it at every falling edge, so every one of these latencies is checked exactly, with no tolerance.

// File: rtl/hlf_pkg.sv
package hlf_pkg;

    typedef enum logic [2:0] {
        C_IDLE,
        C_CTRL,
        C_DATA,
        C_TRG0,
        C_TRG1
    } col_st_e;

    typedef enum logic [2:0] {
        T_IDLE,
        T_WAIT,
        T_HDR,
        T_ADDR,
        T_PASS
    } tx_st_e;

endpackage

// File: rtl/hlf_collect.sv
module hlf_collect
    import hlf_pkg::*;
#(
    parameter int CH    = 64,
    parameter int CHIPW = 5,
    parameter int CHW   = 6,
    parameter int ADDRW = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CHIPW-1:0] nchips_i,
    input  logic             ser_vld_i,
    input  logic             ser_bit_i,
    output logic             busy_o,
    output logic             hit_vld_o,
    output logic [ADDRW-1:0] hit_addr_o,
    output logic             done_o,
    output logic [1:0]       done_tc_o,
    output logic             done_mism_o
);

    typedef struct packed {
        col_st_e          st;
        logic [CHIPW-1:0] chip;
        logic [CHIPW-1:0] nchips;
        logic [CHW-1:0]   ch;
        logic             tc_hi;
        logic [1:0]       tc_ref;
        logic             mism;
    } col_t;

    col_t q, d;
    logic [1:0] tc_now;
    logic       mism_now;

    always_comb begin
        d           = q;
        hit_vld_o   = 1'b0;
        done_o      = 1'b0;
        tc_now      = {q.tc_hi, ser_bit_i};
        mism_now    = q.mism | ((q.chip != '0) && (tc_now != q.tc_ref));
        done_tc_o   = (q.chip == '0) ? tc_now : q.tc_ref;
        done_mism_o = mism_now;
        hit_addr_o  = ADDRW'(q.chip) * ADDRW'(CH) + ADDRW'(q.ch);
        case (q.st)
            C_IDLE: begin
                if (start_i) begin
                    d.st     = C_CTRL;
                    d.chip   = '0;
                    d.mism   = 1'b0;
                    d.nchips = nchips_i;
                end
            end
            C_CTRL: begin
                if (ser_vld_i) begin
                    d.ch = '0;
                    d.st = ser_bit_i ? C_DATA : C_TRG0;
                end
            end
            C_DATA: begin
                if (ser_vld_i) begin
                    hit_vld_o = ser_bit_i;
                    if (q.ch == CHW'(CH - 1)) d.st = C_TRG0;
                    else                      d.ch = q.ch + 1'b1;
                end
            end
            C_TRG0: begin
                if (ser_vld_i) begin
                    d.tc_hi = ser_bit_i;
                    d.st    = C_TRG1;
                end
            end
            C_TRG1: begin
                if (ser_vld_i) begin
                    if (q.chip == '0) d.tc_ref = tc_now;
                    d.mism = mism_now;
                    if (q.chip == q.nchips - 1'b1) begin
                        done_o = 1'b1;
                        d.st   = C_IDLE;
                    end else begin
                        d.chip = q.chip + 1'b1;
                        d.st   = C_CTRL;
                    end
                end
            end
            default: d.st = C_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: C_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy_o = (q.st != C_IDLE);

    assert_addr_in_chain_R1: assert property (@(posedge clk) disable iff (!rst_n)
        hit_vld_o |-> (int'(hit_addr_o) < CH * int'(q.nchips)));

    assert_gap_holds_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != C_IDLE && !ser_vld_i) |=> ($stable(q.ch) && $stable(q.chip)));

endmodule

// File: rtl/hlf_evbuf.sv
module hlf_evbuf #(
    parameter int MAX_HITS = 64,
    parameter int ADDRW    = 11,
    parameter int CNTW     = 7,
    parameter int IDXW     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             hit_vld_i,
    input  logic [ADDRW-1:0] hit_addr_i,
    input  logic             done_i,
    input  logic [1:0]       done_tc_i,
    input  logic             done_mism_i,
    input  logic [IDXW-1:0]  rd_idx_i,
    input  logic             rel_i,
    output logic             wr_free_o,
    output logic             rd_full_o,
    output logic [CNTW-1:0]  rd_cnt_o,
    output logic [1:0]       rd_tc_o,
    output logic             rd_mism_o,
    output logic             rd_ovf_o,
    output logic [ADDRW-1:0] rd_addr_o
);

    typedef struct packed {
        logic                  wsel;
        logic                  rsel;
        logic [1:0]            full;
        logic [CNTW-1:0]       cnt;
        logic                  ovf;
        logic [1:0][CNTW-1:0]  bcnt;
        logic [1:0][1:0]       btc;
        logic [1:0]            bmism;
        logic [1:0]            bovf;
    } buf_t;

    buf_t q, d;
    logic we;
    logic [ADDRW-1:0] mem [2][MAX_HITS];

    always_comb begin
        d  = q;
        we = 1'b0;
        if (start_i) begin
            d.cnt = '0;
            d.ovf = 1'b0;
        end
        if (hit_vld_i) begin
            if (q.cnt < CNTW'(MAX_HITS)) begin
                we    = 1'b1;
                d.cnt = q.cnt + 1'b1;
            end else begin
                d.ovf = 1'b1;
            end
        end
        if (done_i) begin
            d.full[q.wsel]  = 1'b1;
            d.bcnt[q.wsel]  = q.cnt;
            d.btc[q.wsel]   = done_tc_i;
            d.bmism[q.wsel] = done_mism_i;
            d.bovf[q.wsel]  = q.ovf;
            d.wsel          = ~q.wsel;
        end
        if (rel_i) begin
            d.full[q.rsel] = 1'b0;
            d.rsel         = ~q.rsel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (we) mem[q.wsel][q.cnt[IDXW-1:0]] <= hit_addr_i;
    end

    assign wr_free_o = ~q.full[q.wsel];
    assign rd_full_o = q.full[q.rsel];
    assign rd_cnt_o  = q.bcnt[q.rsel];
    assign rd_tc_o   = q.btc[q.rsel];
    assign rd_mism_o = q.bmism[q.rsel];
    assign rd_ovf_o  = q.bovf[q.rsel];
    assign rd_addr_o = mem[q.rsel][rd_idx_i];

    assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNTW'(MAX_HITS));

    assert_done_into_free_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_i |-> !q.full[q.wsel]);

endmodule

// File: rtl/hlf_tx.sv
module hlf_tx
    import hlf_pkg::*;
#(
    parameter int ADDRW = 11,
    parameter int CNTW  = 7,
    parameter int IDXW  = 6,
    parameter int WW    = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             token_i,
    input  logic             busy_i,
    input  logic             rd_full_i,
    input  logic [CNTW-1:0]  rd_cnt_i,
    input  logic [1:0]       rd_tc_i,
    input  logic             rd_mism_i,
    input  logic             rd_ovf_i,
    input  logic [ADDRW-1:0] rd_addr_i,
    output logic [IDXW-1:0]  rd_idx_o,
    output logic             rel_o,
    output logic             out_vld_o,
    output logic [WW-1:0]    out_data_o,
    output logic             out_par_o,
    output logic             out_last_o,
    output logic             token_o
);

    typedef struct packed {
        tx_st_e          st;
        logic [IDXW-1:0] idx;
        logic            sent;
    } tx_t;

    tx_t q, d;
    logic at_end;

    always_comb begin
        d      = q;
        at_end = (CNTW'(q.idx) == rd_cnt_i - 1'b1);
        case (q.st)
            T_IDLE: begin
                if (token_i) begin
                    if (rd_full_i) begin
                        d.st   = T_HDR;
                        d.sent = 1'b1;
                    end else if (busy_i) begin
                        d.st = T_WAIT;
                    end else begin
                        d.st   = T_PASS;
                        d.sent = 1'b0;
                    end
                end
            end
            T_WAIT: begin
                if (rd_full_i) begin
                    d.st   = T_HDR;
                    d.sent = 1'b1;
                end
            end
            T_HDR: begin
                d.idx = '0;
                d.st  = (rd_cnt_i == '0) ? T_PASS : T_ADDR;
            end
            T_ADDR: begin
                if (at_end) d.st  = T_PASS;
                else        d.idx = q.idx + 1'b1;
            end
            T_PASS: d.st = T_IDLE;
            default: d.st = T_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: T_IDLE, default: '0};
        else        q <= d;
    end

    assign rd_idx_o   = q.idx;
    assign rel_o      = (q.st == T_PASS) && q.sent;
    assign token_o    = (q.st == T_PASS);
    assign out_vld_o  = (q.st == T_HDR) || (q.st == T_ADDR);
    assign out_data_o = (q.st == T_HDR) ? WW'({rd_cnt_i, rd_tc_i, rd_mism_i, rd_ovf_i})
                      : (q.st == T_ADDR) ? WW'(rd_addr_i) : '0;
    assign out_par_o  = ^out_data_o;
    assign out_last_o = ((q.st == T_HDR) && (rd_cnt_i == '0)) ||
                        ((q.st == T_ADDR) && at_end);

    assert_token_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld_o && out_last_o) |=> token_o);

    assert_token_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        token_o |=> !token_o);

    assert_send_only_stored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_vld_o) |-> rd_full_i);

endmodule

// File: rtl/hitlist_fmt.sv
module hitlist_fmt #(
    parameter int CHAN_PER_CHIP = 64,
    parameter int MAX_CHIPS     = 24,
    parameter int MAX_HITS      = 64,
    localparam int CHIPW = $clog2(MAX_CHIPS + 1),
    localparam int CHW   = $clog2(CHAN_PER_CHIP),
    localparam int ADDRW = $clog2(MAX_CHIPS * CHAN_PER_CHIP),
    localparam int CNTW  = $clog2(MAX_HITS + 1),
    localparam int IDXW  = $clog2(MAX_HITS),
    localparam int HDRW  = CNTW + 4,
    localparam int WW    = (ADDRW > HDRW) ? ADDRW : HDRW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CHIPW-1:0] cfg_chips,
    input  logic             read_evt,
    input  logic             ser_vld,
    input  logic             ser_bit,
    input  logic             token_in,
    output logic             out_vld,
    output logic [WW-1:0]    out_data,
    output logic             out_par,
    output logic             out_last,
    output logic             mism_err,
    output logic             token_out
);

    typedef struct packed {
        logic err;
    } top_t;

    top_t q, d;

    logic             busy, wr_free, start;
    logic             hit_vld, done, done_mism;
    logic [ADDRW-1:0] hit_addr, rd_addr;
    logic [1:0]       done_tc, rd_tc;
    logic             rd_full, rd_mism, rd_ovf, rel;
    logic [CNTW-1:0]  rd_cnt;
    logic [IDXW-1:0]  rd_idx;

    assign start = read_evt && !busy && wr_free;

    hlf_collect #(
        .CH(CHAN_PER_CHIP), .CHIPW(CHIPW), .CHW(CHW), .ADDRW(ADDRW)
    ) u_collect (
        .clk(clk), .rst_n(rst_n), .start_i(start), .nchips_i(cfg_chips),
        .ser_vld_i(ser_vld), .ser_bit_i(ser_bit), .busy_o(busy),
        .hit_vld_o(hit_vld), .hit_addr_o(hit_addr), .done_o(done),
        .done_tc_o(done_tc), .done_mism_o(done_mism)
    );

    hlf_evbuf #(
        .MAX_HITS(MAX_HITS), .ADDRW(ADDRW), .CNTW(CNTW), .IDXW(IDXW)
    ) u_evbuf (
        .clk(clk), .rst_n(rst_n), .start_i(start), .hit_vld_i(hit_vld),
        .hit_addr_i(hit_addr), .done_i(done), .done_tc_i(done_tc),
        .done_mism_i(done_mism), .rd_idx_i(rd_idx), .rel_i(rel),
        .wr_free_o(wr_free), .rd_full_o(rd_full), .rd_cnt_o(rd_cnt),
        .rd_tc_o(rd_tc), .rd_mism_o(rd_mism), .rd_ovf_o(rd_ovf),
        .rd_addr_o(rd_addr)
    );

    hlf_tx #(
        .ADDRW(ADDRW), .CNTW(CNTW), .IDXW(IDXW), .WW(WW)
    ) u_tx (
        .clk(clk), .rst_n(rst_n), .token_i(token_in), .busy_i(busy),
        .rd_full_i(rd_full), .rd_cnt_i(rd_cnt), .rd_tc_i(rd_tc),
        .rd_mism_i(rd_mism), .rd_ovf_i(rd_ovf), .rd_addr_i(rd_addr),
        .rd_idx_o(rd_idx), .rel_o(rel), .out_vld_o(out_vld),
        .out_data_o(out_data), .out_par_o(out_par), .out_last_o(out_last),
        .token_o(token_out)
    );

    always_comb begin
        d     = q;
        d.err = done && done_mism;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mism_err = q.err;

    assert_err_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mism_err |=> !mism_err);

endmodule

// File: tb/hitlist_fmt_tb.sv
`timescale 1ns/1ps
module hitlist_fmt_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg_chips = 5'd1;
    logic        read_evt = 1'b0, ser_vld = 1'b0, ser_bit = 1'b0, token_in = 1'b0;
    logic        out_vld, out_par, out_last, mism_err, token_out;
    logic [10:0] out_data;

    always #4 clk = ~clk;

    hitlist_fmt u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_chips(cfg_chips), .read_evt(read_evt),
        .ser_vld(ser_vld), .ser_bit(ser_bit), .token_in(token_in),
        .out_vld(out_vld), .out_data(out_data), .out_par(out_par),
        .out_last(out_last), .mism_err(mism_err), .token_out(token_out)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    string cur_req = "R11";

    // stimulus description
    bit hm [24][64];
    int tcs [24];
    bit ev_bits [$];
    logic [10:0] ev_frame [$];
    bit ev_mism;

    // behavioural reference model
    bit          started = 0;
    bit          m_busy, m_wsel, m_rsel, m_sent;
    bit          m_full [2];
    bit          f_old [2];
    bit          busy_old;
    int          m_left, m_tx, m_idx;
    logic [10:0] m_fr0 [$], m_fr1 [$], m_cur [$], frm [$];
    bit          m_cur_mism;
    logic        e_vld, e_par, e_last, e_tok, e_err;
    logic [10:0] e_data;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            m_busy = 0; m_wsel = 0; m_rsel = 0; m_sent = 0;
            m_full[0] = 0; m_full[1] = 0; m_tx = 0; m_idx = 0; m_left = 0;
            e_vld = 0; e_par = 0; e_last = 0; e_tok = 0; e_err = 0; e_data = '0;
        end else begin
            f_old[0] = m_full[0]; f_old[1] = m_full[1]; busy_old = m_busy;
            e_err = 0;
            if (m_busy) begin
                if (ser_vld) begin
                    m_left = m_left - 1;
                    if (m_left == 0) begin
                        m_full[m_wsel] = 1;
                        if (m_wsel) m_fr1 = m_cur; else m_fr0 = m_cur;
                        m_wsel = ~m_wsel;
                        m_busy = 0;
                        e_err = m_cur_mism;
                    end
                end
            end else if (read_evt && !f_old[m_wsel]) begin
                m_busy = 1; m_left = ev_bits.size(); m_cur = ev_frame; m_cur_mism = ev_mism;
            end
            frm = m_rsel ? m_fr1 : m_fr0;
            case (m_tx)
                0: if (token_in) begin
                       if (f_old[m_rsel]) begin m_tx = 2; m_idx = 0; m_sent = 1; end
                       else if (busy_old) m_tx = 1;
                       else begin m_tx = 3; m_sent = 0; end
                   end
                1: if (f_old[m_rsel]) begin m_tx = 2; m_idx = 0; m_sent = 1; end
                2: if (m_idx == frm.size() - 1) m_tx = 3; else m_idx = m_idx + 1;
                default: begin
                    if (m_sent) begin m_full[m_rsel] = 0; m_rsel = ~m_rsel; end
                    m_tx = 0;
                end
            endcase
            frm = m_rsel ? m_fr1 : m_fr0;
            e_vld  = (m_tx == 2);
            e_tok  = (m_tx == 3);
            e_data = e_vld ? frm[m_idx] : '0;
            e_par  = ^e_data;
            e_last = e_vld && (m_idx == frm.size() - 1);
        end
        started = 1;
        if (cyc > 150000) begin
            n_bad = n_bad + 1;
            $display("FAIL R11 watchdog: cycles %0d expected below 150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (started) begin
            n_cmp = n_cmp + 1;
            if (!((out_vld === e_vld) && (token_out === e_tok) && (mism_err === e_err) &&
                  (!e_vld || (out_data === e_data && out_par === e_par && out_last === e_last)))) begin
                n_bad = n_bad + 1;
                $display("FAIL %s t=%0t: vld/data/par/last/tok/err got %b/%h/%b/%b/%b/%b expected %b/%h/%b/%b/%b/%b",
                         cur_req, $time, out_vld, out_data, out_par, out_last, token_out, mism_err,
                         e_vld, e_data, e_par, e_last, e_tok, e_err);
            end
        end
    end

    task automatic clear_ev();
        for (int c = 0; c < 24; c++) begin
            tcs[c] = 0;
            for (int k = 0; k < 64; k++) hm[c][k] = 0;
        end
    endtask

    task automatic build(input int n);
        int addrs [$];
        int cnt;
        bit any;
        ev_bits.delete(); ev_frame.delete(); ev_mism = 0;
        for (int c = 0; c < n; c++) begin
            any = 0;
            for (int k = 0; k < 64; k++) if (hm[c][k]) any = 1;
            ev_bits.push_back(any);
            if (any) for (int k = 0; k < 64; k++) begin
                ev_bits.push_back(hm[c][k]);
                if (hm[c][k]) addrs.push_back(c * 64 + k);
            end
            ev_bits.push_back(tcs[c][1]);
            ev_bits.push_back(tcs[c][0]);
            if (c > 0 && tcs[c] != tcs[0]) ev_mism = 1;
        end
        cnt = (addrs.size() > 64) ? 64 : addrs.size();
        ev_frame.push_back({7'(cnt), 2'(tcs[0]), ev_mism, (addrs.size() > 64)});
        for (int i = 0; i < cnt; i++) ev_frame.push_back(11'(addrs[i]));
    endtask

    // R13: cfg_chips is disturbed right after every accepted request
    task automatic run_event(input int n, input bit gap);
        build(n);
        @(negedge clk); cfg_chips = 5'(n); read_evt = 1;
        @(negedge clk); read_evt = 0; cfg_chips = 5'd1;
        for (int i = 0; i < ev_bits.size(); i++) begin
            if (gap && (i % 3 == 1)) begin ser_vld = 0; @(negedge clk); end
            ser_vld = 1; ser_bit = ev_bits[i];
            @(negedge clk);
        end
        ser_vld = 0; ser_bit = 0;
    endtask

    task automatic pulse_tok();
        @(negedge clk); token_in = 1;
        @(negedge clk); token_in = 0;
        repeat (75) @(negedge clk);
    endtask

    initial begin
        clear_ev();
        repeat (3) @(negedge clk);
        cur_req = "R11";
        rst_n = 1;
        repeat (3) @(negedge clk);

        cur_req = "R1 R5 R6 R7 R13";
        clear_ev();
        hm[0][0] = 1; hm[0][5] = 1; hm[0][63] = 1; hm[1][1] = 1;
        tcs[0] = 2; tcs[1] = 2;
        run_event(2, 0);
        pulse_tok();

        cur_req = "R2";
        clear_ev();
        hm[2][10] = 1; tcs[0] = 1; tcs[1] = 1; tcs[2] = 1;
        run_event(3, 0);
        pulse_tok();

        cur_req = "R3";
        clear_ev();
        hm[0][7] = 1; tcs[0] = 2; tcs[1] = 1;
        run_event(2, 0);
        pulse_tok();

        cur_req = "R4";
        clear_ev();
        for (int k = 0; k < 64; k++) hm[0][k] = 1;
        for (int k = 0; k < 6; k++) hm[1][k * 9] = 1;
        tcs[0] = 3; tcs[1] = 3;
        run_event(2, 0);
        pulse_tok();

        cur_req = "R12";
        clear_ev();
        hm[0][3] = 1; hm[11][32] = 1; hm[23][63] = 1;
        run_event(24, 1);
        pulse_tok();

        cur_req = "R8";
        clear_ev();
        hm[1][20] = 1; hm[2][2] = 1;
        fork
            run_event(3, 0);
            begin repeat (5) @(negedge clk); token_in = 1; @(negedge clk); token_in = 0; end
        join
        repeat (20) @(negedge clk);

        cur_req = "R9";
        pulse_tok();

        cur_req = "R10";
        clear_ev(); hm[0][1] = 1; tcs[0] = 1;
        run_event(1, 0);
        clear_ev(); hm[1][2] = 1; hm[1][3] = 1;
        run_event(2, 0);
        clear_ev(); hm[0][9] = 1;
        run_event(1, 0);
        repeat (3) @(negedge clk);
        pulse_tok();
        pulse_tok();
        pulse_tok();

        repeat (5) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule